// File: doc/BRIEF.md
# Runt-Free Differential Clock Output Gate

This block fans one source clock out to six true/complement output pairs and one feedback clock. Every pair has its own enable, picked out of two 8-bit configuration bytes through a sparse bit map. A pair that is switched off releases both legs. The outputs are modelled as a data vector plus an output-enable vector, and an external pad drives high impedance wherever the enable is low. The feedback clock always runs.

Enable changes cross into the output clock domain through two flops clocked on the falling edge. As a result, an output enable only changes while the source clock is low. The true leg therefore never emits a shortened high pulse, and the complement leg never emits a shortened high pulse either, because its high phase begins at that same falling edge.

A test input picks the source clock. In normal operation the source is the clock that arrives from the upstream loop. In bypass the raw reference clock is routed straight to all outputs.

Top module: `diffclk_gate`

## Requirements
- R1: While a pair is driven, `pair_t[i]` equals the source clock and `pair_c[i]` is its inverse: low source gives t=0, c=1, and high source gives t=1, c=0.
- R2: `pair_oe[i]` = 1 drives both legs of pair i, and `pair_oe[i]` = 0 places both legs in high impedance.
- R3: `fb_clk` follows the source clock under every configuration, including all pairs disabled.
- R4: `pair_oe` changes only while the source clock is low, at a falling edge, so no runt pulse reaches any leg.
- R5: The enable map is: pair 0 = `cfg_a[7]`, pair 1 = `cfg_a[6]`, pair 2 = `cfg_a[3]`, pair 3 = `cfg_b[6]`, pair 4 = `cfg_a[0]`, pair 5 = `cfg_a[2]`.
- R6: Every other configuration bit (`cfg_a[5]`, `cfg_a[4]`, `cfg_a[1]`, and all of `cfg_b` except bit 6) has no effect on `pair_oe`.
- R7: With `test_bypass` = 1 the source clock is `clk_ref`. With `test_bypass` = 0 it is `clk_pll`.
- R8: A configuration change that is held stable appears on `pair_oe` at the second falling edge of the source clock after the change, never at the first, and so well within three output clock cycles.
- R9: `rst` (active high, sampled on the falling edge of the source clock) forces every `pair_oe` bit to 1, whatever the configuration bytes hold. After release, the configured value returns per R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Raw reference clock, used as the source in bypass |
| clk_pll | input | 1 | Clock from the upstream loop, used as the source in normal mode |
| rst | input | 1 | Active-high reset, synchronous to the source clock falling edge |
| test_bypass | input | 1 | 1 selects `clk_ref` as the source |
| cfg_a | input | 8 | First enable byte (sparse map) |
| cfg_b | input | 8 | Second enable byte (only bit 6 used) |
| pair_t | output | 6 | True leg data per pair |
| pair_c | output | 6 | Complement leg data per pair |
| pair_oe | output | 6 | Per-pair output enable, 0 = both legs high impedance |
| fb_clk | output | 1 | Feedback clock, always driven |

## Verification
The properties assume that `cfg_a` and `cfg_b` change at most once per source period and then hold for at least two falling edges. The stimulus meets this by writing the bytes half a nanosecond after a rising edge of the source and waiting for the scoreboard to retire each item before the next write. The properties also assume that `test_bypass` toggles only while both candidate clocks are low, so that the clock selection itself makes no glitch. The bench flips it only in the window after the delayed loop clock falls and before the reference rises. Reset is held across several falling edges so that the two-edge history the checker relies on is always defined.

// File: rtl/diffclk_pkg.sv
`timescale 1ns/1ps
package diffclk_pkg;

  localparam int DEF_PAIRS = 6;
  localparam int DEF_CFG_W = 8;

  // Select mask over {cfg_b, cfg_a} for a pair; one-hot, zero for unmapped pairs.
  function automatic logic [2*DEF_CFG_W-1:0] pair_mask(input int idx);
    logic [2*DEF_CFG_W-1:0] m;
    m = '0;
    case (idx)
      0:       m[7]              = 1'b1;
      1:       m[6]              = 1'b1;
      2:       m[3]              = 1'b1;
      3:       m[DEF_CFG_W + 6]  = 1'b1;
      4:       m[0]              = 1'b1;
      5:       m[2]              = 1'b1;
      default: m                 = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/diffclk_src_sel.sv
`timescale 1ns/1ps
module diffclk_src_sel (
  input  logic clk_ref,
  input  logic clk_pll,
  input  logic bypass,
  output logic src_clk
);

  // Static test selection; switched only while both clocks are low.
  assign src_clk = bypass ? clk_ref : clk_pll;

endmodule

// File: rtl/diffclk_enable_map.sv
`timescale 1ns/1ps
module diffclk_enable_map #(
  parameter int NUM_PAIRS = diffclk_pkg::DEF_PAIRS,
  parameter int CFG_W     = diffclk_pkg::DEF_CFG_W
) (
  input  logic [CFG_W-1:0]     cfg_a,
  input  logic [CFG_W-1:0]     cfg_b,
  output logic [NUM_PAIRS-1:0] pair_en
);

  localparam int ALL_W = 2 * CFG_W;

  logic [ALL_W-1:0] cfg_all;
  assign cfg_all = {cfg_b, cfg_a};

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pick
    localparam logic [ALL_W-1:0] SEL = diffclk_pkg::pair_mask(g);
    assign pair_en[g] = |(cfg_all & SEL);
  end

endmodule

// File: rtl/diffclk_sync_fall.sv
`timescale 1ns/1ps
module diffclk_sync_fall #(
  parameter int           W       = diffclk_pkg::DEF_PAIRS,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  // Both stages load on the falling edge, so q only moves during the low phase.
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(negedge clk) begin
      if (rst) begin
        stage1[g] <= RST_VAL[g];
        stage2[g] <= RST_VAL[g];
      end else begin
        stage1[g] <= d[g];
        stage2[g] <= stage1[g];
      end
    end
  end

  assign q = stage2;

endmodule

// File: rtl/diffclk_pair_drv.sv
`timescale 1ns/1ps
module diffclk_pair_drv (
  input  logic src_clk,
  input  logic en,
  output logic leg_t,
  output logic leg_c,
  output logic leg_oe
);

  assign leg_t  = src_clk;
  assign leg_c  = ~src_clk;
  assign leg_oe = en;

endmodule

// File: rtl/diffclk_gate.sv
`timescale 1ns/1ps
module diffclk_gate #(
  parameter int NUM_PAIRS = diffclk_pkg::DEF_PAIRS,
  parameter int CFG_W     = diffclk_pkg::DEF_CFG_W
) (
  input  logic                 clk_ref,
  input  logic                 clk_pll,
  input  logic                 rst,
  input  logic                 test_bypass,
  input  logic [CFG_W-1:0]     cfg_a,
  input  logic [CFG_W-1:0]     cfg_b,
  output logic [NUM_PAIRS-1:0] pair_t,
  output logic [NUM_PAIRS-1:0] pair_c,
  output logic [NUM_PAIRS-1:0] pair_oe,
  output logic                 fb_clk
);

  localparam logic [NUM_PAIRS-1:0] EN_DEFAULT = '1;

  logic                 src_clk;
  logic [NUM_PAIRS-1:0] pair_en;
  logic [NUM_PAIRS-1:0] pair_en_q;

  diffclk_src_sel u_sel (
    .clk_ref (clk_ref),
    .clk_pll (clk_pll),
    .bypass  (test_bypass),
    .src_clk (src_clk)
  );

  diffclk_enable_map #(
    .NUM_PAIRS (NUM_PAIRS),
    .CFG_W     (CFG_W)
  ) u_map (
    .cfg_a   (cfg_a),
    .cfg_b   (cfg_b),
    .pair_en (pair_en)
  );

  diffclk_sync_fall #(
    .W       (NUM_PAIRS),
    .RST_VAL (EN_DEFAULT)
  ) u_sync (
    .clk (src_clk),
    .rst (rst),
    .d   (pair_en),
    .q   (pair_en_q)
  );

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    diffclk_pair_drv u_drv (
      .src_clk (src_clk),
      .en      (pair_en_q[g]),
      .leg_t   (pair_t[g]),
      .leg_c   (pair_c[g]),
      .leg_oe  (pair_oe[g])
    );
  end

  // Feedback leg has no enable path.
  assign fb_clk = src_clk;

endmodule

// File: rtl/diffclk_gate_chk.sv
`timescale 1ns/1ps
module diffclk_gate_chk #(
  parameter int NUM_PAIRS = diffclk_pkg::DEF_PAIRS,
  parameter int CFG_W     = diffclk_pkg::DEF_CFG_W
) (
  input logic                 clk_ref,
  input logic                 clk_pll,
  input logic                 rst,
  input logic                 test_bypass,
  input logic [CFG_W-1:0]     cfg_a,
  input logic [CFG_W-1:0]     cfg_b,
  input logic [NUM_PAIRS-1:0] pair_t,
  input logic [NUM_PAIRS-1:0] pair_c,
  input logic [NUM_PAIRS-1:0] pair_oe,
  input logic                 fb_clk,
  input logic                 src_clk
);

  logic [NUM_PAIRS-1:0] want_en;
  always_comb begin
    for (int i = 0; i < NUM_PAIRS; i++)
      want_en[i] = |({cfg_b, cfg_a} & diffclk_pkg::pair_mask(i));
  end

  // R1
  legs_follow_chk: assert property (@(posedge clk_pll) disable iff (rst)
    (pair_t == {NUM_PAIRS{fb_clk}}) && (pair_c == ~pair_t));

  // R3
  fb_running_chk: assert property (@(posedge clk_pll) disable iff (rst)
    !test_bypass |-> (fb_clk == clk_pll));

  // R7
  bypass_src_chk: assert property (@(posedge clk_pll) disable iff (rst)
    test_bypass |-> (fb_clk == clk_ref));

  // R8
  en_latency_chk: assert property (@(negedge src_clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2)) |-> (pair_oe == $past(want_en, 2)));

  // R9
  rst_default_chk: assert property (@(negedge src_clk) disable iff (rst)
    $fell(rst) |-> (pair_oe == {NUM_PAIRS{1'b1}}));

  // R4
  always @(pair_oe) begin
    if (!rst) begin
      oe_low_phase_chk: assert (src_clk == 1'b0);
    end
  end

endmodule

bind diffclk_gate diffclk_gate_chk #(
  .NUM_PAIRS (NUM_PAIRS),
  .CFG_W     (CFG_W)
) u_chk (
  .clk_ref     (clk_ref),
  .clk_pll     (clk_pll),
  .rst         (rst),
  .test_bypass (test_bypass),
  .cfg_a       (cfg_a),
  .cfg_b       (cfg_b),
  .pair_t      (pair_t),
  .pair_c      (pair_c),
  .pair_oe     (pair_oe),
  .fb_clk      (fb_clk),
  .src_clk     (src_clk)
);

// File: tb/diffclk_gate_bench.sv
`timescale 1ns/1ps
module diffclk_gate_bench;

  localparam int NP = 6;
  localparam int CW = 8;

  typedef struct {
    logic [NP-1:0] prev;
    logic [NP-1:0] exp;
    string         tag;
  } sb_item_t;

  logic clk_ref = 1'b0;
  logic clk_pll = 1'b0;
  logic rst = 1'b1;
  logic test_bypass = 1'b0;
  logic [CW-1:0] cfg_a = 8'hFF;
  logic [CW-1:0] cfg_b = 8'hC0;
  wire  [NP-1:0] pair_t, pair_c, pair_oe;
  wire           fb_clk;

  int checks = 0;
  int fails = 0;
  int pushed = 0;
  int retired = 0;
  int r4_bad = 0;
  logic [NP-1:0] last_exp = '1;
  sb_item_t sb_q[$];

  // 200 MHz reference; loop clock lags by a quarter period.
  always #2.5 clk_ref = ~clk_ref;
  initial begin
    #1.25;
    forever #2.5 clk_pll = ~clk_pll;
  end

  wire src_b = test_bypass ? clk_ref : clk_pll;

  diffclk_gate u_diffclk_gate (
    .clk_ref     (clk_ref),
    .clk_pll     (clk_pll),
    .rst         (rst),
    .test_bypass (test_bypass),
    .cfg_a       (cfg_a),
    .cfg_b       (cfg_b),
    .pair_t      (pair_t),
    .pair_c      (pair_c),
    .pair_oe     (pair_oe),
    .fb_clk      (fb_clk)
  );

  // R5: expected enables from the requirement's bit map
  function automatic logic [NP-1:0] model_en(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return {a[2], a[0], b[6], a[3], a[6], a[7]};
  endfunction

  function automatic int map_pos(input int idx);
    case (idx)
      0: return 7;
      1: return 6;
      2: return 3;
      3: return 14;
      4: return 0;
      default: return 2;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: writes the bytes after a source rising edge and queues the expectation.
  task automatic set_cfg(input logic [CW-1:0] a, input logic [CW-1:0] b, input string tag);
    sb_item_t it;
    @(posedge src_b);
    #0.5;
    cfg_a = a;
    cfg_b = b;
    it.prev = last_exp;
    it.exp  = model_en(a, b);
    it.tag  = tag;
    last_exp = it.exp;
    sb_q.push_back(it);
    pushed++;
    wait (retired == pushed);
  endtask

  // Monitor: first falling edge must keep the old value, second shows the new one (R8).
  initial begin
    sb_item_t it;
    forever begin
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      @(negedge src_b);
      #1;
      check(pair_oe == it.prev, "R8", {"first edge holds ", it.tag}, 32'(pair_oe), 32'(it.prev));
      @(negedge src_b);
      #1;
      check(pair_oe == it.exp, it.tag, "second edge value", 32'(pair_oe), 32'(it.exp));
      retired++;
    end
  end

  // R4 watcher: enable moves only in the low phase
  always @(pair_oe) begin
    if (!rst && src_b) r4_bad++;
  end

  task automatic check_phases(input string tag);
    @(posedge src_b);
    #0.6;
    check(pair_t == '1 && pair_c == '0, "R1", {"high phase ", tag}, {pair_t, pair_c}, {6'h3F, 6'h00});
    check(fb_clk == 1'b1, "R3", {"fb high ", tag}, 32'(fb_clk), 32'd1);
    @(negedge src_b);
    #0.6;
    check(pair_t == '0 && pair_c == '1, "R1", {"low phase ", tag}, {pair_t, pair_c}, {6'h00, 6'h3F});
    check(fb_clk == 1'b0, "R3", {"fb low ", tag}, 32'(fb_clk), 32'd0);
  endtask

  task automatic set_bypass(input logic v);
    @(negedge clk_pll);
    #0.5;
    test_bypass = v;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #500000;
    checks++;
    fails++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] walk;
    // R9: reset forces all enables on even with bytes cleared
    cfg_a = 8'h00;
    cfg_b = 8'h00;
    repeat (4) @(negedge clk_pll);
    #1;
    check(pair_oe == 6'h3F, "R9", "reset state", 32'(pair_oe), 32'h3F);
    cfg_a = 8'hFF;
    cfg_b = 8'hC0;
    @(posedge src_b);
    #0.5;
    rst = 1'b0;
    repeat (3) @(negedge src_b);
    #1;
    check(pair_oe == 6'h3F, "R9", "defaults after release", 32'(pair_oe), 32'h3F);

    check_phases("all on");

    // R2: all pairs released, clocks still run (R1, R3)
    set_cfg(8'h00, 8'h00, "R2");
    check_phases("all off");

    // R5: one mapped bit at a time
    for (int i = 0; i < NP; i++) begin
      walk = 16'h0000;
      walk[map_pos(i)] = 1'b1;
      set_cfg(walk[7:0], walk[15:8], "R5");
    end

    // R6: reserved bits only, then mapped bits with reserved bits toggling
    set_cfg(8'h32, 8'hBF, "R6");
    set_cfg(8'hCD, 8'h40, "R5");
    set_cfg(8'hFF, 8'hFF, "R6");
    set_cfg(8'hCD, 8'h40, "R6");
    set_cfg(8'h88, 8'h40, "R5");
    set_cfg(8'h45, 8'h00, "R5");

    // R7: bypass routes the reference clock
    @(posedge clk_ref);
    #0.5;
    check(fb_clk == 1'b0, "R7", "normal source is loop clock", 32'(fb_clk), 32'd0);
    set_bypass(1'b1);
    @(posedge clk_ref);
    #0.5;
    check(fb_clk == 1'b1, "R7", "bypass source is reference", 32'(fb_clk), 32'd1);
    set_cfg(8'h04, 8'h40, "R7");
    check_phases("bypass");
    set_bypass(1'b0);
    @(posedge clk_ref);
    #0.5;
    check(fb_clk == 1'b0, "R7", "back to loop clock", 32'(fb_clk), 32'd0);

    // R9: mid-run reset with all bytes cleared
    set_cfg(8'h00, 8'h00, "R5");
    @(posedge src_b);
    #0.5;
    rst = 1'b1;
    repeat (2) @(negedge src_b);
    #1;
    check(pair_oe == 6'h3F, "R9", "mid-run reset", 32'(pair_oe), 32'h3F);
    @(posedge src_b);
    #0.5;
    rst = 1'b0;
    repeat (2) @(negedge src_b);
    #1;
    check(pair_oe == 6'h00, "R9", "configured value returns", 32'(pair_oe), 32'h0);

    check(r4_bad == 0, "R4", "enable moved in high phase", 32'(r4_bad), 32'd0);
    finish_run();
  end

endmodule